// File: doc/BRIEF.md
# UART Register Front End with Watermark Interrupts

This block sits between a 32-bit word-wide register bus and the line-side logic of a UART. Software writes bytes to be sent into a transmit queue and takes received bytes out of a receive queue, both through single registers. The serializer drains the transmit queue through a byte-wide valid/ready pop port. The deserializer delivers bytes through a byte-wide push port that has no back-pressure.

Two control registers each hold a 3-bit watermark level. The pending register compares both queue occupancies against those levels. An enable register gates each pending bit onto one level-sensitive interrupt line. A divisor register is only stored and driven out to a baud generator that lies outside this block.

Register reads are combinational in the same cycle as the request. Side effects, such as removing a received byte, take place at the clock edge that ends the access.

Top module: `uart_csr_front`

## Requirements
- R1: TX control (offset 0x08), RX control (0x0C) and interrupt enable (0x10) read back all 32 bits last written. The divisor (0x18) keeps the low DIV_W bits, reads back zero-extended, and drives `baud_div`.
- R2: An access is taken only when `bus_be` is 4'hF. For any other strobe pattern a write changes nothing, a read returns zero, and no byte is removed.
- R3: A write to TX data (0x00) appends bits 7:0 to the transmit queue. `tx_valid` is high while the queue is non-empty, and `tx_data` shows the oldest byte. A byte leaves the queue on a cycle with `tx_valid` and `tx_ready` both high.
- R4: A TX data write to a full transmit queue is dropped unless a line-side pop occurs in the same cycle. A TX data read returns the full flag in bit 31 and zeros elsewhere.
- R5: A read of RX data (0x04) with the receive queue non-empty returns the oldest byte in bits 7:0, with the other bits zero, and removes that byte.
- R6: A read of RX data with the receive queue empty returns 32'h8000_0000 and changes nothing.
- R7: A byte pushed on `rx_push` while the receive queue holds 8 entries is discarded unless an RX data read removes a byte in the same cycle.
- R8: The pending register (0x14) has bit 0 set when the TX occupancy is strictly less than TX control bits 18:16, and bit 1 set when the RX occupancy is strictly greater than RX control bits 18:16. All other bits are zero.
- R9: `irq` equals (pending bit 0 AND enable bit 0) OR (pending bit 1 AND enable bit 1).
- R10: Writes to RX data, to the pending register and to unmapped offsets have no effect. Reads of unmapped offsets return zero.
- R11: Reset empties both queues and clears both control registers, the enable register and the divisor, so `irq`, `tx_valid` and `baud_div` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_be | input | 4 | Byte strobes; only 4'hF is accepted |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the request cycle |
| tx_data | output | 8 | Oldest byte in the transmit queue |
| tx_valid | output | 1 | Transmit queue non-empty |
| tx_ready | input | 1 | Line side takes `tx_data` |
| rx_push | input | 1 | Line side delivers a received byte |
| rx_byte | input | 8 | Received byte |
| baud_div | output | 16 | Stored divisor value |
| irq | output | 1 | Level interrupt |

## Verification
The embedded properties take all inputs to be known, not X, from the first edge after reset. Apart from the byte strobes, they place no ordering limits on the bus or line ports: a pop on an empty queue, a push into a full one and a read of an empty RX register are all legal input patterns that the design must absorb. The stimulus keeps every input at a defined value and draws offsets from the mapped set plus one unmapped and one misaligned value. Partial strobes appear in about one access in eight. Directed phases drive both queues past full and past empty, so the dropping and empty-read paths that the properties guard are actually reached.

// File: rtl/uart_csr_pkg.sv
package uart_csr_pkg;
   localparam int unsigned ADDR_W = 5;
   localparam int unsigned WM_LSB = 16;
   localparam int unsigned WM_W   = 3;
   localparam int unsigned FLAG_BIT = 31;

   typedef enum logic [ADDR_W-1:0] {
      OFF_TXD = 5'h00,
      OFF_RXD = 5'h04,
      OFF_TXC = 5'h08,
      OFF_RXC = 5'h0C,
      OFF_IEN = 5'h10,
      OFF_IPD = 5'h14,
      OFF_DIV = 5'h18
   } csr_off_e;
endpackage

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned W     = 8,
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   input  logic [W-1:0]  din,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty
);
   localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   initial assert (DEPTH >= 2) else $error("uart_byte_fifo: DEPTH must be at least 2");

   logic [W-1:0]  mem_q [DEPTH];
   logic [PW-1:0] wp_q, rp_q, wp_nx, rp_nx;
   logic          do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign do_pop  = pop && !empty;
   assign do_push = push && (!full || do_pop);

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wp_nx = wp_q + PW'(1);
         assign rp_nx = rp_q + PW'(1);
      end else begin : g_wrap
         assign wp_nx = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + PW'(1);
         assign rp_nx = (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + PW'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         count <= '0;
      end else begin
         if (do_push) wp_q <= wp_nx;
         if (do_pop)  rp_q <= rp_nx;
         count <= count + CW'(do_push) - CW'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem_q[wp_q] <= din;
   end

   assign dout = mem_q[rp_q];

   // R7
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));

   // R7
   full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> (count == CW'(DEPTH)));

   // R6
   empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push) |=> empty);
endmodule

// File: rtl/uart_wm_irq.sv
module uart_wm_irq #(
   parameter int unsigned CW   = 4,
   parameter int unsigned WM_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [CW-1:0]   tx_cnt,
   input  logic [CW-1:0]   rx_cnt,
   input  logic [WM_W-1:0] tx_lvl,
   input  logic [WM_W-1:0] rx_lvl,
   input  logic [1:0]      ien,
   output logic [1:0]      pend,
   output logic            irq
);
   localparam int unsigned MW = (CW > WM_W) ? CW : WM_W;

   assign pend[0] = MW'(tx_cnt) < MW'(tx_lvl);
   assign pend[1] = MW'(rx_cnt) > MW'(rx_lvl);
   assign irq     = |(pend & ien);

   // R9
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ien != 2'b00));

   // R8
   rx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_cnt == '0) |-> !pend[1]);
endmodule

// File: rtl/uart_csr_front.sv
module uart_csr_front
   import uart_csr_pkg::*;
#(
   parameter int unsigned FIFO_DEPTH = 8,
   parameter int unsigned DIV_W      = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [3:0]        bus_be,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic [7:0]        tx_data,
   output logic              tx_valid,
   input  logic              tx_ready,
   input  logic              rx_push,
   input  logic [7:0]        rx_byte,
   output logic [DIV_W-1:0]  baud_div,
   output logic              irq
);
   localparam int unsigned CW = $clog2(FIFO_DEPTH + 1);

   initial assert (DIV_W >= 1 && DIV_W <= 32) else $error("uart_csr_front: DIV_W out of range");

   logic             acc, rd, wr;
   logic [31:0]      txc_q, rxc_q, ien_q;
   logic [DIV_W-1:0] div_q;
   logic [CW-1:0]    tx_cnt, rx_cnt;
   logic             tx_full, tx_empty, rx_full, rx_empty;
   logic [7:0]       rx_head;
   logic [1:0]       pend;
   logic             tx_wr, rx_rd;

   assign acc   = bus_sel && (bus_be == 4'hF);
   assign rd    = acc && !bus_we;
   assign wr    = acc && bus_we;
   assign tx_wr = wr && (bus_addr == OFF_TXD);
   assign rx_rd = rd && (bus_addr == OFF_RXD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         txc_q <= '0;
         rxc_q <= '0;
         ien_q <= '0;
         div_q <= '0;
      end else if (wr) begin
         case (bus_addr)
            OFF_TXC: txc_q <= bus_wdata;
            OFF_RXC: rxc_q <= bus_wdata;
            OFF_IEN: ien_q <= bus_wdata;
            OFF_DIV: div_q <= bus_wdata[DIV_W-1:0];
            default: ;
         endcase
      end
   end

   uart_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_txq (
      .clk(clk), .rst_n(rst_n),
      .push(tx_wr), .pop(tx_ready), .din(bus_wdata[7:0]),
      .dout(tx_data), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
   );

   uart_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_rxq (
      .clk(clk), .rst_n(rst_n),
      .push(rx_push), .pop(rx_rd), .din(rx_byte),
      .dout(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
   );

   uart_wm_irq #(.CW(CW), .WM_W(WM_W)) u_irq (
      .clk(clk), .rst_n(rst_n),
      .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
      .tx_lvl(txc_q[WM_LSB +: WM_W]), .rx_lvl(rxc_q[WM_LSB +: WM_W]),
      .ien(ien_q[1:0]), .pend(pend), .irq(irq)
   );

   assign tx_valid = !tx_empty;
   assign baud_div = div_q;

   always_comb begin
      bus_rdata = '0;
      if (rd) begin
         case (bus_addr)
            OFF_TXD: bus_rdata[FLAG_BIT] = tx_full;
            OFF_RXD: begin
               if (rx_empty) bus_rdata[FLAG_BIT] = 1'b1;
               else          bus_rdata[7:0]      = rx_head;
            end
            OFF_TXC: bus_rdata = txc_q;
            OFF_RXC: bus_rdata = rxc_q;
            OFF_IEN: bus_rdata = ien_q;
            OFF_IPD: bus_rdata[1:0] = pend;
            OFF_DIV: bus_rdata = 32'(div_q);
            default: ;
         endcase
      end
   end

   // R6
   rx_empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_we && bus_be == 4'hF && bus_addr == OFF_RXD && rx_cnt == '0)
         |-> (bus_rdata == 32'h8000_0000));

   // R2
   partial_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_be != 4'hF) |-> (bus_rdata == 32'h0));

   // R1
   ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && bus_we && bus_be == 4'hF && bus_addr == OFF_TXC) |=> $stable(txc_q));

   // R4
   tx_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_full && !tx_ready) |=> !tx_empty);
endmodule

// File: tb/uart_csr_front_test.sv
module uart_csr_front_test;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_we = 1'b0;
   logic [3:0]  bus_be = 4'h0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  tx_data;
   logic        tx_valid;
   logic        tx_ready = 1'b0;
   logic        rx_push = 1'b0;
   logic [7:0]  rx_byte = '0;
   logic [15:0] baud_div;
   logic        irq;

   int n_vec = 0, n_bad = 0;
   bit done = 0;

   byte unsigned tq[$], rq[$];
   logic [31:0] m_txc = 0, m_rxc = 0, m_ien = 0, m_div = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   uart_csr_front uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_be(bus_be),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .rx_push(rx_push), .rx_byte(rx_byte), .baud_div(baud_div), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [1:0] m_pend();
      logic [1:0] p;
      p[0] = tq.size() < int'(m_txc[18:16]);
      p[1] = rq.size() > int'(m_rxc[18:16]);
      return p;
   endfunction

   function automatic logic [31:0] m_rdata(logic sel, logic we, logic [3:0] be, logic [4:0] a);
      if (!(sel && !we && be == 4'hF)) return 32'h0;
      case (a)
         5'h00: return {tq.size() == DEPTH, 31'h0};
         5'h04: return (rq.size() == 0) ? 32'h8000_0000 : {24'h0, rq[0]};
         5'h08: return m_txc;
         5'h0C: return m_rxc;
         5'h10: return m_ien;
         5'h14: return {30'h0, m_pend()};
         5'h18: return m_div;
         default: return 32'h0;
      endcase
   endfunction

   function automatic string tag_of(logic [3:0] be, logic [4:0] a);
      if (be != 4'hF) return "R2";
      case (a)
         5'h00: return "R4";
         5'h04: return (rq.size() == 0) ? "R6" : "R5";
         5'h08, 5'h0C, 5'h10, 5'h18: return "R1";
         5'h14: return "R8";
         default: return "R10";
      endcase
   endfunction

   task automatic step(input logic sel, input logic we, input logic [3:0] be, input logic [4:0] a,
                       input logic [31:0] wd, input logic txr, input logic rxp, input logic [7:0] rxb);
      logic [1:0] p;
      bit acc, rdrx, txpop, txpush, rxpush;
      @(negedge clk);
      bus_sel = sel; bus_we = we; bus_be = be; bus_addr = a; bus_wdata = wd;
      tx_ready = txr; rx_push = rxp; rx_byte = rxb;
      #1;
      chk(tag_of(be, a), bus_rdata, m_rdata(sel, we, be, a));
      p = m_pend();
      // R9
      chk("R9 irq", {31'h0, irq}, {31'h0, (p[0] & m_ien[0]) | (p[1] & m_ien[1])});
      // R3
      chk("R3 tx_valid", {31'h0, tx_valid}, {31'h0, tq.size() != 0});
      if (tq.size() != 0) chk("R3 tx_data", {24'h0, tx_data}, {24'h0, tq[0]});
      chk("R1 baud_div", {16'h0, baud_div}, m_div);
      @(posedge clk);
      acc    = sel && be == 4'hF;
      rdrx   = acc && !we && a == 5'h04 && rq.size() != 0;
      txpop  = txr && tq.size() != 0;
      txpush = acc && we && a == 5'h00 && (tq.size() < DEPTH || txpop);
      rxpush = rxp && (rq.size() < DEPTH || rdrx);
      if (rdrx)   void'(rq.pop_front());
      if (txpop)  void'(tq.pop_front());
      if (txpush) tq.push_back(wd[7:0]);
      if (rxpush) rq.push_back(rxb);
      if (acc && we) begin
         case (a)
            5'h08: m_txc = wd;
            5'h0C: m_rxc = wd;
            5'h10: m_ien = wd;
            5'h18: m_div = {16'h0, wd[15:0]};
            default: ;
         endcase
      end
   endtask

   task automatic rd(input logic [4:0] a);
      step(1, 0, 4'hF, a, 0, 0, 0, 0);
   endtask
   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      step(1, 1, 4'hF, a, d, 0, 0, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      logic [4:0] amap [9];
      amap = '{5'h00, 5'h04, 5'h08, 5'h0C, 5'h10, 5'h14, 5'h18, 5'h1C, 5'h02};
      void'($urandom(32'd20240611));
      #(CLK_PERIOD * 3 + 2);
      // R11 reset state at the ports
      chk("R11 irq", {31'h0, irq}, 0);
      chk("R11 tx_valid", {31'h0, tx_valid}, 0);
      chk("R11 baud_div", {16'h0, baud_div}, 0);
      rst_n = 1'b1;
      for (int i = 0; i < 7; i++) rd(amap[i]);
      // R1 readback
      wr(5'h08, 32'hDEAD_BEEF); wr(5'h0C, 32'h1234_5678); wr(5'h10, 32'hFFFF_FFFC);
      wr(5'h18, 32'hABCD_9876);
      for (int i = 2; i < 7; i++) rd(amap[i]);
      // R10 ignored writes, unmapped read
      wr(5'h04, 32'hFF); wr(5'h14, 32'h3); wr(5'h1C, 32'h55);
      rd(5'h1C); rd(5'h04); rd(5'h14);
      // R2 partial strobes
      step(1, 1, 4'h1, 5'h08, 32'h0, 0, 0, 0); rd(5'h08);
      // R4 fill TX past full, watermark and interrupts
      wr(5'h08, 32'h0007_0000); wr(5'h10, 32'h3);
      for (int i = 0; i < DEPTH + 2; i++) wr(5'h00, 32'h100 + i);
      rd(5'h00); rd(5'h14);
      for (int i = 0; i < DEPTH + 1; i++) step(0, 0, 4'h0, 0, 0, 1, 0, 0);
      // R7 RX overflow, R5 drain, R6 empty read
      wr(5'h0C, 32'h0007_0000);
      for (int i = 0; i < DEPTH + 3; i++) step(0, 0, 4'h0, 0, 0, 0, 1, 8'hA0 + 8'(i));
      rd(5'h14);
      for (int i = 0; i < DEPTH + 2; i++) rd(5'h04);
      // R2 partial read of RX does not pop
      step(0, 0, 4'h0, 0, 0, 0, 1, 8'h5A);
      step(1, 0, 4'h3, 5'h04, 0, 0, 0, 0); rd(5'h04);
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] r;
         r = $urandom;
         step(r[0] | r[1], r[2], (r[5:3] == 3'd0) ? 4'(r[9:6]) : 4'hF,
              amap[$urandom % 9], (r[10]) ? $urandom : {13'h0, 3'($urandom), 16'($urandom)},
              r[11] & r[12], r[13], 8'($urandom));
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule